// File: doc/BRIEF.md
# Deep-Sleep Power Mode Sequencer

This block tracks whether the device is in full-speed run or reduced-power run, and it decides which stop state to enter when the processor asks for deep sleep. Two configuration words select the behaviour. An allow word, which can be written once after reset, unlocks the deeper states. A mode word holds the stop selection, the run-speed choice, a keep-reference-clock flag and a reset enable for low-voltage detect. The block drives clock and power-domain enables that follow the current state.

While in stop, the block watches wakeup lines and reset-class events. A wakeup resumes execution in the run mode the stop was entered from. A reset-class event, or a wakeup from any of the three deepest states, leaves stop only through a reset request. That path also returns both configuration words to their reset values.

Top module: `pwr_stop_seq`

## Requirements
- R1: The allow word (bit0 reduced-power states, bit1 low-leakage stop, bit2 very-low-leakage stops) is accepted once after reset. Later allow writes are ignored. An allow write with any bit above bit2 set is ignored and does not lock.
- R2: A mode-word write is ignored entirely if bits above bit5 are nonzero, if its stop code is reserved (001 or 100), if the stop code or the run-speed bit needs a state that the allow word forbids, or if it arrives while the block is not in idle run. Mode word fields: [2:0] stop code, [3] reduced-power run, [4] keep reference clock in stop, [5] low-voltage-detect reset enable.
- R3: In idle run, the mode output follows the run-speed bit one cycle after the write lands: 0 for full run, 2 for reduced-power run.
- R4: A sleep request without the deep-sleep flag changes nothing, even if an acknowledge follows.
- R5: A sleep request with the deep-sleep flag arms the block. The mode changes only on the cycle the acknowledge is sampled while armed. From full run, stop codes map as follows: 000 gives stop (1), 010 gives reduced-power stop (3), 011 gives low-leakage stop (4), and 101/110/111 give very-low-leakage stops 1/2/3 (5/6/7).
- R6: From reduced-power run, stop codes 000 and 010 both give reduced-power stop (3). Other codes map as in R5.
- R7: In stop (1), reduced-power stop (3) or low-leakage stop (4), any wakeup line returns the mode to the run mode the stop was entered from, with no reset request.
- R8: In any stop state, a reset pin, a watchdog timeout, or a low-voltage detect with bit5 set raises the reset request for one cycle and sets the mode to 0. A wakeup from states 5 to 7 does the same. A reset event takes priority over a simultaneous wakeup. A low-voltage detect with bit5 clear is ignored.
- R9: The enables {core clock, reference clock, logic power, RAM power} follow the mode one cycle later: run modes 1111, stop 0k11, reduced-power stop 0011, low-leakage stop 0001, level 1 0000, levels 2 and 3 0001.
- R10: In stop, the reference clock enable k equals the keep bit of the mode word.
- R11: After reset, the mode is 0, all enables are 1 and the reset request is 0.
- R12: Configuration writes made while armed or in any stop state leave both words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the allow word, 1 selects the mode word |
| cfg_wdata | input | DW | Write data |
| sleep_req | input | 1 | Core sleep request |
| sleep_deep | input | 1 | Core deep-sleep flag |
| sleep_ack | input | 1 | Core acknowledge of the sleep handshake |
| wake_src | input | NWAKE | Enabled asynchronous wakeup lines |
| rst_pin | input | 1 | External reset pin event |
| wdog_to | input | 1 | Watchdog timeout |
| lvd_det | input | 1 | Low-voltage detect |
| mode_o | output | 3 | Current mode code |
| clk_core_en | output | 1 | Core/bus clock enable |
| clk_ref_en | output | 1 | Reference clock enable |
| pwr_logic_en | output | 1 | Logic power domain enable |
| pwr_ram_en | output | 1 | RAM power domain enable |
| rst_req_o | output | 1 | One-cycle reset-exit request |

## Verification
The bench uses the defaults DW = 8 and NWAKE = 7. With an 8-bit write bus, the bench can write reserved upper bits, so the reject-on-reserved-bit rules for both words can be reached. With seven wakeup lines, the bench can drive a single line at a random position, which shows that any one of them is enough to wake the block. Random traffic applies the handshake, wakeups and reset events in every state and compares each cycle against a bench model. Directed steps cover the priority, lock and lag corners.

// File: rtl/pwr_stop_pkg.sv
package pwr_stop_pkg;

    typedef enum logic [2:0] {
        M_RUN   = 3'd0,
        M_STOP  = 3'd1,
        M_VLPR  = 3'd2,
        M_VLPS  = 3'd3,
        M_LLS   = 3'd4,
        M_VLLS1 = 3'd5,
        M_VLLS2 = 3'd6,
        M_VLLS3 = 3'd7
    } pmode_e;

    typedef struct packed {
        logic allow_vlls;
        logic allow_ll;
        logic allow_vlp;
    } prot_t;

    typedef struct packed {
        logic       lvd_rst_en;
        logic       ref_keep;
        logic       run_vlp;
        logic [2:0] stop_code;
    } ctl_t;

    typedef struct packed {
        logic clk_core;
        logic clk_ref;
        logic pwr_logic;
        logic pwr_ram;
    } gate_t;

    localparam int CTL_W  = $bits(ctl_t);
    localparam int PROT_W = $bits(prot_t);

    function automatic logic is_run(pmode_e m);
        return (m == M_RUN) || (m == M_VLPR);
    endfunction

    function automatic logic code_ok(ctl_t c, prot_t p);
        logic ok;
        case (c.stop_code)
            3'b000:                 ok = 1'b1;
            3'b010:                 ok = p.allow_vlp;
            3'b011:                 ok = p.allow_ll;
            3'b101, 3'b110, 3'b111: ok = p.allow_vlls;
            default:                ok = 1'b0;
        endcase
        return ok && (!c.run_vlp || p.allow_vlp);
    endfunction

    function automatic pmode_e pick_target(ctl_t c, logic from_vlp);
        pmode_e t;
        case (c.stop_code)
            3'b011:  t = M_LLS;
            3'b101:  t = M_VLLS1;
            3'b110:  t = M_VLLS2;
            3'b111:  t = M_VLLS3;
            default: t = (from_vlp || c.stop_code == 3'b010) ? M_VLPS : M_STOP;
        endcase
        return t;
    endfunction

    function automatic gate_t gates_for(pmode_e m, logic keep);
        gate_t g;
        case (m)
            M_RUN, M_VLPR:   g = 4'b1111;
            M_STOP:          g = {1'b0, keep, 2'b11};
            M_VLPS:          g = 4'b0011;
            M_LLS:           g = 4'b0001;
            M_VLLS1:         g = 4'b0000;
            default:         g = 4'b0001;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pwr_stop_regs.sv
module pwr_stop_regs
    import pwr_stop_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          open,
    input  logic          we,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    output ctl_t          ctl
);
    prot_t prot;
    logic  locked;
    ctl_t  ctl_new;
    logic  ctl_hi_zero;
    logic  prot_hi_zero;

    assign ctl_new      = ctl_t'(wdata[CTL_W-1:0]);
    assign ctl_hi_zero  = (wdata[DW-1:CTL_W] == '0);
    assign prot_hi_zero = (wdata[DW-1:PROT_W] == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prot   <= '0;
            ctl    <= '0;
            locked <= 1'b0;
        end else if (we && open) begin
            if (!sel) begin
                if (!locked && prot_hi_zero) begin
                    prot   <= prot_t'(wdata[PROT_W-1:0]);
                    locked <= 1'b1;
                end
            end else if (ctl_hi_zero && code_ok(ctl_new, prot)) begin
                ctl <= ctl_new;
            end
        end
    end

    // R1: once locked, the allow word holds until a clear
    p_lock_hold_r1: assert property (@(posedge clk) disable iff (rst)
        locked && !clr |=> $stable(prot));

    // R2: every stored mode word is legal under the allow word
    p_ctl_legal_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(clr) && ctl != $past(ctl) |-> code_ok(ctl, prot));

endmodule

// File: rtl/pwr_stop_fsm.sv
module pwr_stop_fsm
    import pwr_stop_pkg::*;
#(
    parameter int NWAKE = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             sleep_deep,
    input  logic             sleep_ack,
    input  logic [NWAKE-1:0] wake_src,
    input  logic             rst_pin,
    input  logic             wdog_to,
    input  logic             lvd_det,
    input  ctl_t             ctl,
    output pmode_e           mode_q,
    output logic             rst_req_q,
    output logic             open,
    output logic             clr
);
    logic   armed_q;
    logic   org_vlp_q;
    pmode_e tgt_q;
    logic   in_stop;
    logic   rst_evt;
    logic   wake;
    logic   deep_lvl;

    assign in_stop  = !is_run(mode_q);
    assign rst_evt  = rst_pin || wdog_to || (lvd_det && ctl.lvd_rst_en);
    assign wake     = |wake_src;
    assign deep_lvl = (mode_q == M_VLLS1) || (mode_q == M_VLLS2) || (mode_q == M_VLLS3);
    assign clr      = in_stop && (rst_evt || (wake && deep_lvl));
    assign open     = !in_stop && !armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= M_RUN;
            armed_q   <= 1'b0;
            tgt_q     <= M_STOP;
            org_vlp_q <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= clr;
            if (clr) begin
                mode_q    <= M_RUN;
                armed_q   <= 1'b0;
                org_vlp_q <= 1'b0;
            end else if (in_stop) begin
                if (wake) mode_q <= org_vlp_q ? M_VLPR : M_RUN;
            end else if (armed_q) begin
                if (sleep_ack) begin
                    mode_q  <= tgt_q;
                    armed_q <= 1'b0;
                end
            end else if (sleep_req && sleep_deep) begin
                armed_q   <= 1'b1;
                tgt_q     <= pick_target(ctl, mode_q == M_VLPR);
                org_vlp_q <= (mode_q == M_VLPR);
            end else begin
                mode_q <= ctl.run_vlp ? M_VLPR : M_RUN;
            end
        end
    end

    // R8: reset request is a single-cycle pulse and lands in full run
    p_rst_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> !rst_req_q);
    p_rst_run_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |-> mode_q == M_RUN);

    // R5: armed without acknowledge keeps the mode
    p_hold_armed_r5: assert property (@(posedge clk) disable iff (rst)
        armed_q && !sleep_ack |=> mode_q == $past(mode_q));

    // R4: plain sleep never leaves the run modes
    p_nodeep_r4: assert property (@(posedge clk) disable iff (rst)
        open && sleep_req && !sleep_deep |=> is_run(mode_q));

    // R7: shallow-stop wakeup resumes without reset
    p_wake_resume_r7: assert property (@(posedge clk) disable iff (rst)
        in_stop && !deep_lvl && wake && !rst_evt |=> is_run(mode_q) && !rst_req_q);

endmodule

// File: rtl/pwr_stop_gates.sv
module pwr_stop_gates
    import pwr_stop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pmode_e mode,
    input  logic   keep,
    output gate_t  g
);
    always_ff @(posedge clk) begin
        if (rst) g <= '1;
        else     g <= gates_for(mode, keep);
    end

    // R9: core clock follows run membership of the previous cycle
    p_core_lag_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> g.clk_core == is_run($past(mode)));

endmodule

// File: rtl/pwr_stop_seq.sv
module pwr_stop_seq
    import pwr_stop_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NWAKE = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             sleep_req,
    input  logic             sleep_deep,
    input  logic             sleep_ack,
    input  logic [NWAKE-1:0] wake_src,
    input  logic             rst_pin,
    input  logic             wdog_to,
    input  logic             lvd_det,
    output logic [2:0]       mode_o,
    output logic             clk_core_en,
    output logic             clk_ref_en,
    output logic             pwr_logic_en,
    output logic             pwr_ram_en,
    output logic             rst_req_o
);
    ctl_t   ctl;
    pmode_e mode_q;
    logic   open;
    logic   clr;
    gate_t  g;

    pwr_stop_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .clr(clr), .open(open),
        .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata), .ctl(ctl)
    );

    pwr_stop_fsm #(.NWAKE(NWAKE)) u_fsm (
        .clk(clk), .rst(rst),
        .sleep_req(sleep_req), .sleep_deep(sleep_deep), .sleep_ack(sleep_ack),
        .wake_src(wake_src), .rst_pin(rst_pin), .wdog_to(wdog_to), .lvd_det(lvd_det),
        .ctl(ctl), .mode_q(mode_q), .rst_req_q(rst_req_o), .open(open), .clr(clr)
    );

    pwr_stop_gates u_gates (
        .clk(clk), .rst(rst), .mode(mode_q), .keep(ctl.ref_keep), .g(g)
    );

    assign mode_o       = mode_q;
    assign clk_core_en  = g.clk_core;
    assign clk_ref_en   = g.clk_ref;
    assign pwr_logic_en = g.pwr_logic;
    assign pwr_ram_en   = g.pwr_ram;

endmodule

// File: tb/test_pwr_stop_seq.sv
`timescale 1ns/1ps
module test_pwr_stop_seq;
    localparam int DW = 8;
    localparam int NW = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we, cfg_sel, sleep_req, sleep_deep, sleep_ack, rst_pin, wdog_to, lvd_det;
    logic [DW-1:0] cfg_wdata;
    logic [NW-1:0] wake_src;
    logic [2:0] mode_o;
    logic clk_core_en, clk_ref_en, pwr_logic_en, pwr_ram_en, rst_req_o;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_stop_seq #(.DW(DW), .NWAKE(NW)) i_pwr_stop_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .sleep_req(sleep_req), .sleep_deep(sleep_deep), .sleep_ack(sleep_ack),
        .wake_src(wake_src), .rst_pin(rst_pin), .wdog_to(wdog_to), .lvd_det(lvd_det),
        .mode_o(mode_o), .clk_core_en(clk_core_en), .clk_ref_en(clk_ref_en),
        .pwr_logic_en(pwr_logic_en), .pwr_ram_en(pwr_ram_en), .rst_req_o(rst_req_o)
    );

    wire [3:0] gates = {clk_core_en, clk_ref_en, pwr_logic_en, pwr_ram_en};

    // ---------------- reference model from the requirements ----------------
    int m_mode, m_tgt;
    bit m_armed, m_org, m_rst, m_lock;
    logic [2:0] m_prot;
    logic [5:0] m_ctl;
    logic [3:0] m_gates;

    function automatic bit run_m(int m); return m == 0 || m == 2; endfunction

    function automatic bit ctl_ok(logic [7:0] d, logic [2:0] p);
        bit ok;
        case (d[2:0])
            3'b000: ok = 1;
            3'b010: ok = p[0];
            3'b011: ok = p[1];
            3'b101, 3'b110, 3'b111: ok = p[2];
            default: ok = 0;
        endcase
        return ok && d[7:6] == 2'b00 && (!d[3] || p[0]);
    endfunction

    function automatic int tgt_of(logic [2:0] c, bit from_vlp);
        case (c)
            3'b011: return 4;
            3'b101: return 5;
            3'b110: return 6;
            3'b111: return 7;
            default: return (from_vlp || c == 3'b010) ? 3 : 1;
        endcase
    endfunction

    function automatic logic [3:0] gates_of(int m, bit keep);
        case (m)
            0, 2: return 4'b1111;
            1: return {1'b0, keep, 2'b11};
            3: return 4'b0011;
            4: return 4'b0001;
            5: return 4'b0000;
            default: return 4'b0001;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_armed = 0; m_org = 0; m_rst = 0; m_tgt = 1;
            m_prot = 0; m_ctl = 0; m_lock = 0; m_gates = 4'hF;
        end else begin
            bit stp, opn, ev, cl;
            logic [3:0] ng;
            logic [5:0] old_ctl;
            ng = gates_of(m_mode, m_ctl[4]);
            old_ctl = m_ctl;
            stp = !run_m(m_mode);
            opn = !stp && !m_armed;
            ev  = rst_pin || wdog_to || (lvd_det && m_ctl[5]);
            cl  = stp && (ev || ((|wake_src) && m_mode >= 5));
            if (cl) begin
                m_prot = 0; m_ctl = 0; m_lock = 0;
            end else if (cfg_we && opn) begin
                if (!cfg_sel) begin
                    if (!m_lock && cfg_wdata[7:3] == 0) begin m_prot = cfg_wdata[2:0]; m_lock = 1; end
                end else if (ctl_ok(cfg_wdata, m_prot)) m_ctl = cfg_wdata[5:0];
            end
            m_rst = cl;
            if (cl) begin m_mode = 0; m_armed = 0; m_org = 0; end
            else if (stp) begin if (|wake_src) m_mode = m_org ? 2 : 0; end
            else if (m_armed) begin if (sleep_ack) begin m_mode = m_tgt; m_armed = 0; end end
            else if (sleep_req && sleep_deep) begin
                m_armed = 1; m_tgt = tgt_of(old_ctl[2:0], m_mode == 2); m_org = (m_mode == 2);
            end else m_mode = old_ctl[3] ? 2 : 0;
            m_gates = ng;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !rst && !done) begin
            chk("R11 mode", mode_o, m_mode);
            chk("R9 gates", gates, m_gates);
            chk("R8 reset request", rst_req_o, m_rst);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
        sleep_req = 0; sleep_deep = 0; sleep_ack = 0;
        wake_src = '0; rst_pin = 0; wdog_to = 0; lvd_det = 0;
    endtask

    task automatic step(); @(negedge clk); idle(); endtask

    task automatic wr(input bit s, input logic [7:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d; step();
    endtask

    task automatic deep();
        sleep_req = 1; sleep_deep = 1; step();
        sleep_ack = 1; step();
    endtask

    task automatic wrap_up();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        wrap_up();
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cmp_on = 1;
        chk("R11 reset mode", mode_o, 0);
        chk("R11 reset gates", gates, 4'hF);
        chk("R11 reset request", rst_req_o, 0);

        wr(0, 8'h01);               // allow reduced-power only
        wr(0, 8'h07);               // second allow write ignored
        wr(1, 8'h03);               // LLS forbidden
        deep();
        chk("R1 second allow write ignored", mode_o, 1);
        chk("R9 gates lag the mode", gates, 4'hF);
        step();
        chk("R10 stop without keep", gates, 4'b0011);
        wake_src = 7'h10; step();
        chk("R7 wake returns to run", mode_o, 0);

        wr(1, 8'h08); step();
        chk("R3 reduced-power run", mode_o, 2);
        sleep_req = 1; step(); sleep_ack = 1; step();
        chk("R4 sleep without deep flag", mode_o, 2);
        deep();
        chk("R6 from reduced run code 000", mode_o, 3);
        wr(1, 8'h00);               // attempted write in stop
        wake_src = 7'h01; step();
        chk("R7 wake to origin", mode_o, 2);
        step();
        chk("R12 write in stop ignored", mode_o, 2);

        wr(1, 8'h02); step();
        chk("R3 back to full run", mode_o, 0);
        deep();
        chk("R5 code 010 from full run", mode_o, 3);
        wake_src = 7'h02; rst_pin = 1; step();
        chk("R8 reset beats wake", rst_req_o, 1);
        chk("R8 reset lands in run", mode_o, 0);
        step();
        chk("R8 single pulse", rst_req_o, 0);

        wr(0, 8'h04);               // allowed again: clear unlocked it
        wr(1, 8'h15);
        deep();
        chk("R5 code 101", mode_o, 5);
        step();
        chk("R9 deepest gates", gates, 4'b0000);
        wake_src = 7'h40; step();
        chk("R8 deep wake is reset", rst_req_o, 1);

        wr(0, 8'h87);               // reserved bits: ignored, no lock
        wr(0, 8'h02);
        wr(1, 8'h13);               // keep=1, LLS
        deep();
        chk("R2 allow accepted after reserved write", mode_o, 4);
        wake_src = 7'h08; step();
        wr(1, 8'h10); wr(1, 8'hD0); // second has reserved bits
        deep(); step();
        chk("R10 stop with keep", gates, 4'b0111);
        lvd_det = 1; step();
        chk("R8 detect without enable", mode_o, 1);
        wdog_to = 1; step();
        chk("R8 watchdog exit", rst_req_o, 1);

        wr(1, 8'h01);               // reserved code
        sleep_req = 1; sleep_deep = 1; step();
        repeat (5) step();
        chk("R5 armed without acknowledge", mode_o, 0);
        sleep_ack = 1; step();
        chk("R2 reserved code ignored", mode_o, 1);
        wake_src = 7'h04; step();

        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 12) begin
                cfg_we = 1; cfg_sel = $urandom % 2;
                cfg_wdata = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 64);
            end
            sleep_req  = ($urandom % 8) == 0;
            sleep_deep = ($urandom % 3) != 0;
            sleep_ack  = ($urandom % 3) == 0;
            if ($urandom % 15 == 0) wake_src = NW'(1) << ($urandom % NW);
            rst_pin = ($urandom % 60) == 0;
            wdog_to = ($urandom % 60) == 0;
            lvd_det = ($urandom % 30) == 0;
            step();
        end
        wrap_up();
    end
endmodule